// File: doc/BRIEF.md
# Partitioned Add Subtract Compare Unit

This block is a SIMD integer datapath slice for 64-bit and 32-bit operands. One request carries two operands, a 9-bit opcode and a flag that says whether the request is a single (32-bit) form. The block can add or subtract in 16-bit or 32-bit lanes, and each lane wraps on its own. It can compare lanes and return a compact bit mask. It can also widen four bytes into 16-bit fixed-point lanes.

Each accepted request gives one registered result one clock later, with a valid strobe. An opcode the block does not know, or a width flag that does not match the opcode, raises an illegal flag and gives a zero result. Saturation, packing and condition codes are not part of this block.

Top module: `pasc_unit`

## Requirements
- R1: After a synchronous active-low reset, out_valid, out_illegal and out_result are all zero.
- R2: out_valid is high exactly one cycle after a cycle with in_valid high. While in_valid is low, out_result and out_illegal keep their last values.
- R3: Opcode 0x050 adds four 16-bit lanes, where lane i is bits [16i+15:16i]. Opcode 0x051 adds the two 16-bit lanes of the low 32 bits and returns zero in result bits [63:32].
- R4: Opcode 0x052 adds two 32-bit lanes. Opcode 0x053 adds the low 32 bits of each operand as one lane and returns zero in the upper 32 result bits.
- R5: Opcodes 0x054, 0x055, 0x056 and 0x057 subtract the second operand from the first. They use the lane layouts of 0x050, 0x051, 0x052 and 0x053 in that order.
- R6: Every lane sum or difference wraps modulo its lane width. No carry or borrow crosses into the next lane.
- R7: The 16-bit compares use these opcodes: 0x028 signed greater-than, 0x02a equal, 0x020 signed less-or-equal and 0x022 not-equal. Each tests first operand against second. Result bit i is 1 when 16-bit lane i meets the predicate, and bits [63:4] are zero.
- R8: The 32-bit compares use these opcodes: 0x02c signed greater-than, 0x02e equal, 0x024 signed less-or-equal and 0x026 not-equal. They work on the two 32-bit lanes, and result bits [63:2] are zero.
- R9: Opcode 0x04d takes byte i from bits [8i+7:8i] of the first operand and returns byte_i shifted left by 4 in 16-bit lane i. The upper 32 bits of the first operand and all of the second operand have no effect.
- R10: in_single must be 1 for the odd opcodes 0x051, 0x053, 0x055 and 0x057, and 0 for every other legal opcode. Any other opcode, or a flag mismatch, gives out_illegal = 1 and out_result = 0.
- R11: In the single forms, bits [63:32] of both operands have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A request is present this cycle |
| in_op | input | 9 | Operation code |
| in_single | input | 1 | 1 for a single (32-bit) form |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 64 | Registered result |
| out_illegal | output | 1 | The request was not a legal operation |

## Verification
The bench builds the block with its default parameters: a 64-bit word, 16-bit narrow lanes and 32-bit wide lanes. With these values the carry-kill points fall both inside and at the edge of a wide lane, so one run covers both cases. It also lets a wide compare combine a signed upper chunk with an unsigned lower chunk. Random operands are mixed with directed values at the lane edges, such as 0xFFFF plus 1 and 0x8000 against 0x7FFF. Random upper halves on single forms show that those bits are ignored.

// File: rtl/pasc_pkg.sv
// Shared types for the partitioned add/subtract/compare unit.
// Assumes opcodes are 9 bits wide; the encodings are fixed by the decoder.
package pasc_pkg;

    typedef enum logic [2:0] {
        K_ADD = 3'd0,
        K_SUB = 3'd1,
        K_CMP = 3'd2,
        K_EXP = 3'd3,
        K_BAD = 3'd4
    } op_kind_t;

    typedef enum logic [1:0] {
        P_GT = 2'd0,
        P_EQ = 2'd1,
        P_LE = 2'd2,
        P_NE = 2'd3
    } pred_t;

    typedef struct packed {
        op_kind_t kind;
        logic     wide;   // 32-bit lanes instead of 16-bit lanes
        logic     half;   // single form: low 32 bits only
        pred_t    pred;
    } dec_t;

endpackage

// File: rtl/pasc_decode.sv
// Opcode decoder. Turns an opcode and the single-width flag into an
// operation kind, a lane width, a half flag and a compare predicate.
// Assumes in the add/sub group bit 2 selects subtract, bit 1 selects
// 32-bit lanes and bit 0 selects the single form.
module pasc_decode
    import pasc_pkg::*;
#(
    parameter int OP_W = 9
) (
    input  logic [OP_W-1:0] op,
    input  logic            single,
    output dec_t            dec
);

    // Classify the opcode; flag any mismatch with the width flag.
    always_comb begin
        dec      = '{kind: K_BAD, wide: 1'b0, half: 1'b0, pred: P_GT};
        case (op)
            9'h050, 9'h051, 9'h052, 9'h053,
            9'h054, 9'h055, 9'h056, 9'h057: begin
                dec.kind = op[2] ? K_SUB : K_ADD;
                dec.wide = op[1];
                dec.half = op[0];
                if (single != op[0]) dec.kind = K_BAD;
            end
            9'h020, 9'h022, 9'h024, 9'h026,
            9'h028, 9'h02a, 9'h02c, 9'h02e: begin
                dec.kind = single ? K_BAD : K_CMP;
                dec.wide = op[2];
                case ({op[3], op[1]})
                    2'b00:   dec.pred = P_LE;
                    2'b01:   dec.pred = P_NE;
                    2'b10:   dec.pred = P_GT;
                    default: dec.pred = P_EQ;
                endcase
            end
            9'h04d: begin
                dec.kind = single ? K_BAD : K_EXP;
            end
            default: dec.kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/pasc_laneadd.sv
// Partitioned adder/subtractor. Splits the word into narrow chunks.
// A carry passes from one chunk to the next only inside a wide lane.
// Assumes DATA_W is a multiple of WIDE_W and WIDE_W a multiple of NARROW_W.
module pasc_laneadd #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              wide,
    output logic [DATA_W-1:0] sum
);

    localparam int N_CHUNK = DATA_W / NARROW_W;
    localparam int RATIO   = WIDE_W / NARROW_W;

    logic [N_CHUNK:0] cy;

    assign cy[0] = sub;

    for (genvar k = 0; k < N_CHUNK; k++) begin : g_chunk
        localparam bit LANE_EDGE = (k % RATIO) == 0;
        logic [NARROW_W-1:0] bx;
        logic                cin;
        logic [NARROW_W:0]   s;

        // Invert the second operand when subtracting.
        assign bx  = sub ? ~b[k*NARROW_W +: NARROW_W] : b[k*NARROW_W +: NARROW_W];
        // Restart the carry at every lane edge.
        assign cin = (LANE_EDGE || !wide) ? sub : cy[k];
        // Add one chunk, including the carry-in.
        assign s   = {1'b0, a[k*NARROW_W +: NARROW_W]} + {1'b0, bx}
                   + {{NARROW_W{1'b0}}, cin};
        assign sum[k*NARROW_W +: NARROW_W] = s[NARROW_W-1:0];
        assign cy[k+1] = s[NARROW_W];
    end

endmodule

// File: rtl/pasc_lanecmp.sv
// Lane comparator. Compares each narrow chunk signed and unsigned. A wide
// lane is signed on its top chunk and unsigned below it. Returns a packed
// mask in the low bits of the word; all other bits are zero.
// Assumes a is compared against b (a > b for greater-than).
module pasc_lanecmp
    import pasc_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              wide,
    input  pred_t             pred,
    output logic [DATA_W-1:0] mask
);

    localparam int N_CHUNK = DATA_W / NARROW_W;
    localparam int N_WIDE  = DATA_W / WIDE_W;
    localparam int RATIO   = WIDE_W / NARROW_W;

    logic [N_CHUNK-1:0] eq_c, gts_c, gtu_c;
    logic [N_CHUNK-1:0] hit_n;
    logic [N_WIDE-1:0]  hit_w;

    for (genvar k = 0; k < N_CHUNK; k++) begin : g_chunk
        logic [NARROW_W-1:0] ak, bk;
        assign ak = a[k*NARROW_W +: NARROW_W];
        assign bk = b[k*NARROW_W +: NARROW_W];
        // Per-chunk relations, signed and unsigned.
        assign eq_c[k]  = ak == bk;
        assign gts_c[k] = $signed(ak) > $signed(bk);
        assign gtu_c[k] = ak > bk;
    end

    // Apply the predicate to every narrow lane.
    always_comb begin
        for (int k = 0; k < N_CHUNK; k++) begin
            case (pred)
                P_GT:    hit_n[k] = gts_c[k];
                P_EQ:    hit_n[k] = eq_c[k];
                P_LE:    hit_n[k] = !gts_c[k];
                default: hit_n[k] = !eq_c[k];
            endcase
        end
    end

    // Build the wide-lane relations from the top chunk down, then apply the predicate.
    always_comb begin
        logic gt, eq;
        for (int j = 0; j < N_WIDE; j++) begin
            gt = gts_c[j*RATIO + RATIO - 1];
            eq = eq_c[j*RATIO + RATIO - 1];
            for (int c = RATIO - 2; c >= 0; c--) begin
                gt = gt | (eq & gtu_c[j*RATIO + c]);
                eq = eq & eq_c[j*RATIO + c];
            end
            case (pred)
                P_GT:    hit_w[j] = gt;
                P_EQ:    hit_w[j] = eq;
                P_LE:    hit_w[j] = !gt;
                default: hit_w[j] = !eq;
            endcase
        end
    end

    // Pack the chosen mask into the low bits.
    always_comb begin
        mask = '0;
        if (wide) mask[N_WIDE-1:0]  = hit_w;
        else      mask[N_CHUNK-1:0] = hit_n;
    end

endmodule

// File: rtl/pasc_expand.sv
// Byte expander. Puts byte i of the source, shifted left by FRAC_SH, into
// narrow lane i. Assumes NARROW_W >= 8 + FRAC_SH.
module pasc_expand #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 16,
    parameter int FRAC_SH  = 4
) (
    input  logic [DATA_W/2-1:0] src,
    output logic [DATA_W-1:0]   lanes
);

    localparam int N_CHUNK = DATA_W / NARROW_W;
    localparam int PAD_W   = NARROW_W - 8 - FRAC_SH;

    for (genvar k = 0; k < N_CHUNK; k++) begin : g_lane
        // Zero-extend the byte and shift it into the fixed-point position.
        if (PAD_W > 0) begin : g_pad
            assign lanes[k*NARROW_W +: NARROW_W] =
                {{PAD_W{1'b0}}, src[k*8 +: 8], {FRAC_SH{1'b0}}};
        end else begin : g_nopad
            assign lanes[k*NARROW_W +: NARROW_W] = {src[k*8 +: 8], {FRAC_SH{1'b0}}};
        end
    end

endmodule

// File: rtl/pasc_unit.sv
// Partitioned add/subtract/compare unit, top level. Decodes the request,
// runs the three datapaths side by side and registers the selected result
// one cycle after in_valid. Assumes a synchronous active-low reset.
// Result and illegal flag hold while no request arrives.
module pasc_unit
    import pasc_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter int OP_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic              in_single,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_illegal
);

    localparam int HALF_W = DATA_W / 2;

    dec_t              dec;
    logic [DATA_W-1:0] a_eff, b_eff, sum, mask, lanes, nxt;

    pasc_decode #(.OP_W(OP_W)) u_dec (
        .op(in_op), .single(in_single), .dec(dec)
    );

    // Single forms see only the low half of each operand.
    assign a_eff = dec.half ? {{HALF_W{1'b0}}, in_a[HALF_W-1:0]} : in_a;
    assign b_eff = dec.half ? {{HALF_W{1'b0}}, in_b[HALF_W-1:0]} : in_b;

    pasc_laneadd #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_add (
        .a(a_eff), .b(b_eff), .sub(dec.kind == K_SUB), .wide(dec.wide), .sum(sum)
    );

    pasc_lanecmp #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_cmp (
        .a(in_a), .b(in_b), .wide(dec.wide), .pred(dec.pred), .mask(mask)
    );

    pasc_expand #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .FRAC_SH(4)) u_exp (
        .src(in_a[HALF_W-1:0]), .lanes(lanes)
    );

    // Pick the result for the decoded kind; single forms clear the upper half.
    always_comb begin
        case (dec.kind)
            K_ADD, K_SUB: nxt = dec.half ? {{HALF_W{1'b0}}, sum[HALF_W-1:0]} : sum;
            K_CMP:        nxt = mask;
            K_EXP:        nxt = lanes;
            default:      nxt = '0;
        endcase
    end

    // Output register: the strobe follows in_valid, the data loads only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= nxt;
                out_illegal <= (dec.kind == K_BAD);
            end
        end
    end

endmodule

// File: rtl/pasc_unit_chk.sv
// Property checker for pasc_unit, attached with bind. It watches only ports.
module pasc_unit_chk #(
    parameter int DATA_W = 64,
    parameter int OP_W   = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   in_op,
    input logic              in_single,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_illegal
);

    // R2
    strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result) && $stable(out_illegal));
    // R10
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_result == '0));
    // R7
    mask16_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_single && (in_op == 9'h020 || in_op == 9'h022 ||
         in_op == 9'h028 || in_op == 9'h02a)) |=> (out_result[DATA_W-1:4] == '0));
    // R8
    mask32_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_single && (in_op == 9'h024 || in_op == 9'h026 ||
         in_op == 9'h02c || in_op == 9'h02e)) |=> (out_result[DATA_W-1:2] == '0));
    // R3 R4 R5 single forms leave the upper half clear
    single_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_single && (in_op == 9'h051 || in_op == 9'h053 ||
         in_op == 9'h055 || in_op == 9'h057)) |=> (out_result[DATA_W-1:DATA_W/2] == '0));
    // R9
    expand_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_single && in_op == 9'h04d) |=>
        ((out_result & 64'hF00F_F00F_F00F_F00F) == '0));

endmodule

bind pasc_unit pasc_unit_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_single(in_single), .out_valid(out_valid), .out_result(out_result),
    .out_illegal(out_illegal)
);

// File: tb/sim_pasc_unit.sv
module sim_pasc_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [8:0]  in_op = '0;
    logic        in_single = 1'b0;
    logic [63:0] in_a = '0, in_b = '0;
    logic        out_valid, out_illegal;
    logic [63:0] out_result;

    int checks = 0, errors = 0;
    logic [63:0] last_res = '0;
    logic        last_bad = 1'b0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pasc_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_single(in_single), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
    );

    localparam logic [8:0] LEGAL [17] = '{9'h050, 9'h051, 9'h052, 9'h053,
        9'h054, 9'h055, 9'h056, 9'h057, 9'h020, 9'h022, 9'h024, 9'h026,
        9'h028, 9'h02a, 9'h02c, 9'h02e, 9'h04d};

    // Reference model written from the requirements.
    function automatic void ref_model(input logic [8:0] op, input logic single,
                                      input logic [63:0] a, input logic [63:0] b,
                                      output logic [63:0] r, output logic bad);
        logic [15:0] x16, y16;
        logic [31:0] x32, y32;
        logic        hit;
        r = '0; bad = 1'b0;
        if (op >= 9'h050 && op <= 9'h057) begin
            if (single != op[0]) begin bad = 1'b1; return; end
            if (!op[1]) begin
                for (int i = 0; i < (op[0] ? 2 : 4); i++) begin
                    x16 = a[16*i +: 16]; y16 = b[16*i +: 16];
                    r[16*i +: 16] = op[2] ? x16 - y16 : x16 + y16;
                end
            end else begin
                for (int i = 0; i < (op[0] ? 1 : 2); i++) begin
                    x32 = a[32*i +: 32]; y32 = b[32*i +: 32];
                    r[32*i +: 32] = op[2] ? x32 - y32 : x32 + y32;
                end
            end
        end else if (op == 9'h04d) begin
            if (single) begin bad = 1'b1; return; end
            for (int i = 0; i < 4; i++) r[16*i +: 16] = {4'h0, a[8*i +: 8], 4'h0};
        end else if (op inside {9'h020, 9'h022, 9'h028, 9'h02a}) begin
            if (single) begin bad = 1'b1; return; end
            for (int i = 0; i < 4; i++) begin
                x16 = a[16*i +: 16]; y16 = b[16*i +: 16];
                case (op)
                    9'h028:  hit = $signed(x16) >  $signed(y16);
                    9'h020:  hit = $signed(x16) <= $signed(y16);
                    9'h02a:  hit = x16 == y16;
                    default: hit = x16 != y16;
                endcase
                r[i] = hit;
            end
        end else if (op inside {9'h024, 9'h026, 9'h02c, 9'h02e}) begin
            if (single) begin bad = 1'b1; return; end
            for (int i = 0; i < 2; i++) begin
                x32 = a[32*i +: 32]; y32 = b[32*i +: 32];
                case (op)
                    9'h02c:  hit = $signed(x32) >  $signed(y32);
                    9'h024:  hit = $signed(x32) <= $signed(y32);
                    9'h02e:  hit = x32 == y32;
                    default: hit = x32 != y32;
                endcase
                r[i] = hit;
            end
        end else begin
            bad = 1'b1;
        end
    endfunction

    // Requirement tag for a request.
    function automatic string tag_of(input logic [8:0] op, input logic single);
        logic [63:0] r; logic bad;
        ref_model(op, single, '0, '0, r, bad);
        if (bad) return "R10";
        if (op == 9'h050 || op == 9'h051) return "R3";
        if (op == 9'h052 || op == 9'h053) return "R4";
        if (op >= 9'h054 && op <= 9'h057) return "R5";
        if (op == 9'h04d) return "R9";
        if (op inside {9'h024, 9'h026, 9'h02c, 9'h02e}) return "R8";
        return "R7";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One request; sample one cycle later, between clock edges.
    task automatic run_op(input logic [8:0] op, input logic single,
                          input logic [63:0] a, input logic [63:0] b, input string tag);
        logic [63:0] r; logic bad;
        ref_model(op, single, a, b, r, bad);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_single = single; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "out_valid", {63'd0, out_valid}, 64'd1);
        check(tag, "result", out_result, r);
        check(tag, "illegal", {63'd0, out_illegal}, {63'd0, bad});
        last_res = r; last_bad = bad;
    endtask

    // An idle cycle must drop the strobe and hold the data.
    task automatic idle_check(input logic [63:0] junk);
        @(negedge clk);
        in_a = junk; in_b = ~junk; in_op = 9'h050;
        @(negedge clk);
        check("R2", "idle strobe", {63'd0, out_valid}, 64'd0);
        check("R2", "idle hold", out_result, last_res);
        check("R2", "idle illegal hold", {63'd0, out_illegal}, {63'd0, last_bad});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] a, b;
        logic [8:0]  op;
        logic        sg;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "reset valid", {63'd0, out_valid}, 64'd0);
        check("R1", "reset result", out_result, 64'd0);
        check("R1", "reset illegal", {63'd0, out_illegal}, 64'd0);
        rst_n = 1'b1;

        // R6 lane wrap with no carry across lanes
        run_op(9'h050, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, "R6");
        run_op(9'h052, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, "R6");
        run_op(9'h054, 1'b0, 64'h0000_0000_0000_0000, 64'h0001_0000_0001_0000, "R6");
        run_op(9'h056, 1'b0, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, "R6");
        run_op(9'h052, 1'b0, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, "R4");
        // R7/R8 signed edges
        run_op(9'h028, 1'b0, 64'h7FFF_8000_0000_FFFF, 64'h8000_7FFF_0000_0000, "R7");
        run_op(9'h020, 1'b0, 64'h7FFF_8000_0000_FFFF, 64'h8000_7FFF_0000_0000, "R7");
        run_op(9'h02c, 1'b0, 64'h0000_0001_8000_0000, 64'h0000_0000_7FFF_FFFF, "R8");
        run_op(9'h02e, 1'b0, 64'h1234_5678_1234_0000, 64'h1234_5678_1234_5678, "R8");
        run_op(9'h02c, 1'b0, 64'h0001_8000_0000_0000, 64'h0001_7FFF_0000_0000, "R8");
        // R9 expand with junk above and in b
        run_op(9'h04d, 1'b0, 64'hDEAD_BEEF_FF80_7F01, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
        idle_check(64'h5555_AAAA_5555_AAAA);
        // R10 mismatch and unknown
        run_op(9'h050, 1'b1, 64'h1, 64'h2, "R10");
        run_op(9'h051, 1'b0, 64'h1, 64'h2, "R10");
        run_op(9'h04d, 1'b1, 64'h1, 64'h2, "R10");
        run_op(9'h1FF, 1'b0, 64'h1, 64'h2, "R10");
        idle_check(64'h0F0F_0F0F_0F0F_0F0F);
        // R11 upper bits ignored in single forms
        run_op(9'h051, 1'b1, 64'hFFFF_FFFF_0001_FFFF, 64'hABCD_0123_0001_0001, "R11");
        run_op(9'h057, 1'b1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_0000_0001, "R11");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            if ($urandom_range(3) == 0) b = a ^ {48'd0, 16'($urandom_range(1))};
            op = LEGAL[$urandom_range(16)];
            sg = (op >= 9'h050 && op <= 9'h057) ? op[0] : 1'b0;
            case ($urandom_range(9))
                0: sg = ~sg;
                1: op = 9'($urandom);
                default: ;
            endcase
            run_op(op, sg, a, b, tag_of(op, sg));
            if ((n % 37) == 0) idle_check({$urandom, $urandom});
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule